// File: doc/BRIEF.md
# Lamp ballast mode sequencer

This block steps a half-bridge fluorescent lamp ballast through its operating modes: lockout, preheat, a short timing-capacitor discharge, ignition, pre-run, run and a latched fault. Every analog quantity reaches it as a digital comparator flag. These flags cover the supply against its on and off thresholds, the bus-monitor enable and disable levels, the shutdown pin low and high levels, the preheat timing capacitor at one third, one half and two thirds of supply, and the current-sense over-limit. Trip requests from an external over-current event counter and an end-of-life filter also arrive as flags.

The sequencer passes every flag through a two-stage synchroniser before using it. It then drives the oscillator enable, the timing-capacitor discharge switch, the switch that holds the frequency-ramp node shorted, a one-clock sink pulse that regulates ignition current, and a 3-bit mode code. The timing capacitor passes its thresholds twice. The first pass ends preheat. The second pass splits ignition from pre-run and pre-run from run. The block reacts to over-current differently in each mode: it regulates in ignition, trips at once in pre-run, and defers to the event counter in preheat and run.

Top module: `ballast_seq`

## Requirements
- R1: During and after reset the mode is lockout (code 0). In lockout the oscillator is off, the discharge switch is on and the ramp hold is on. The mode codes are: 0 lockout, 1 preheat, 2 preheat discharge, 3 ignition, 4 pre-run, 5 run, 7 fault.
- R2: Lockout moves to preheat only when `vdd_on`, `bus_en` and `sd_low` are all high. Because of the synchroniser, the mode changes on the third rising clock edge after the inputs settle.
- R3: In preheat the oscillator runs, the discharge switch is off and the ramp hold is on. When `tc_2third` is seen, the mode moves to preheat discharge.
- R4: In preheat discharge the oscillator runs and both the discharge switch and the ramp hold are on. When `tc_third` goes low, the mode moves to ignition.
- R5: In ignition the ramp hold and the discharge switch are off. Each rising edge of the synchronised `oc_over` produces exactly one clock of `reg_sink`. `reg_sink` is never high outside ignition.
- R6: Ignition moves to pre-run when `tc_half` is seen. In pre-run a single `oc_over` sends the block to fault.
- R7: Pre-run moves to run when `tc_2third` is seen. In run the oscillator is on and both switches are off.
- R8: `cnt_trip` sends preheat, preheat discharge and run to fault. `eol_trip` sends run to fault. In ignition and pre-run both trips are ignored.
- R9: Fault stops the oscillator and turns on both the discharge switch and the ramp hold. Fault is latched against every input except its exits.
- R10: Fault exits only to lockout, and only when `vdd_off` or `sd_high` is seen.
- R11: Any mode from preheat to run drops to lockout when `vdd_off` or `bus_dis` is seen. Once the lockout conditions recover, the sequence restarts from preheat.
- R12: When a lockout cause and a fault cause are seen in the same clock, lockout wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_on | input | 1 | Supply above rising threshold |
| vdd_off | input | 1 | Supply below falling threshold |
| bus_en | input | 1 | Bus monitor above enable level |
| bus_dis | input | 1 | Bus monitor below disable level |
| sd_low | input | 1 | Shutdown input below its low level |
| sd_high | input | 1 | Shutdown input above its high level |
| tc_third | input | 1 | Timing capacitor above one third of supply |
| tc_half | input | 1 | Timing capacitor above one half of supply |
| tc_2third | input | 1 | Timing capacitor above two thirds of supply |
| oc_over | input | 1 | Current sense above limit |
| cnt_trip | input | 1 | Over-current event counter trip request |
| eol_trip | input | 1 | End-of-life filter trip request |
| osc_en | output | 1 | Oscillator enable |
| cap_dump | output | 1 | Timing-capacitor discharge switch |
| ramp_hold | output | 1 | Frequency-ramp node short |
| reg_sink | output | 1 | Ignition regulation sink pulse |
| mode | output | 3 | Mode code |

## Verification
The assertions watch only the mode sequence and the output decode. They rely on the mode register changing only through the legal paths, and on the synchronised over-current flag needing a full clock low before it can rise again. The stimulus keeps the flags physically consistent. The supply is never both above its on threshold and below its off threshold, the shutdown level is never both low and high, and the capacitor flags always form a thermometer code. Each random setting is held for several clocks, so the synchronised values settle.

// File: rtl/ballast_seq.sv
module ballast_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vdd_on,
  input  logic       vdd_off,
  input  logic       bus_en,
  input  logic       bus_dis,
  input  logic       sd_low,
  input  logic       sd_high,
  input  logic       tc_third,
  input  logic       tc_half,
  input  logic       tc_2third,
  input  logic       oc_over,
  input  logic       cnt_trip,
  input  logic       eol_trip,
  output logic       osc_en,
  output logic       cap_dump,
  output logic       ramp_hold,
  output logic       reg_sink,
  output logic [2:0] mode
);
  localparam int NF = 12;

  typedef enum logic [2:0] {
    ST_LOCK = 3'd0, ST_PRE = 3'd1, ST_DUMP = 3'd2, ST_IGN = 3'd3,
    ST_PRUN = 3'd4, ST_RUN = 3'd5, ST_FLT = 3'd7
  } state_t;

  logic [NF-1:0] raw;
  logic [NF-1:0] sq [SYNC_STAGES];
  logic [NF-1:0] f;
  logic          oc_d;
  state_t        st, nxt;

  assign raw = {eol_trip, cnt_trip, oc_over, tc_2third, tc_half, tc_third,
                sd_high, sd_low, bus_dis, bus_en, vdd_off, vdd_on};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sq[i] <= '0;
    end else begin
      sq[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
    end
  end

  assign f = sq[SYNC_STAGES-1];

  wire s_vdd_on  = f[0];
  wire s_vdd_off = f[1];
  wire s_bus_en  = f[2];
  wire s_bus_dis = f[3];
  wire s_sd_low  = f[4];
  wire s_sd_high = f[5];
  wire s_third   = f[6];
  wire s_half    = f[7];
  wire s_2third  = f[8];
  wire s_oc      = f[9];
  wire s_cnt     = f[10];
  wire s_eol     = f[11];

  always_comb begin
    nxt = st;
    case (st)
      ST_LOCK: if (s_vdd_on && s_bus_en && s_sd_low) nxt = ST_PRE;
      ST_FLT:  if (s_vdd_off || s_sd_high) nxt = ST_LOCK;
      default: begin
        if (s_vdd_off || s_bus_dis) nxt = ST_LOCK;
        else begin
          case (st)
            ST_PRE:  if (s_cnt) nxt = ST_FLT; else if (s_2third) nxt = ST_DUMP;
            ST_DUMP: if (s_cnt) nxt = ST_FLT; else if (!s_third) nxt = ST_IGN;
            ST_IGN:  if (s_half) nxt = ST_PRUN;
            ST_PRUN: if (s_oc) nxt = ST_FLT; else if (s_2third) nxt = ST_RUN;
            ST_RUN:  if (s_cnt || s_eol) nxt = ST_FLT;
            default: nxt = ST_LOCK;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_LOCK;
      oc_d <= 1'b0;
    end else begin
      st   <= nxt;
      oc_d <= s_oc;
    end
  end

  assign mode      = st;
  assign osc_en    = (st != ST_LOCK) && (st != ST_FLT);
  assign cap_dump  = (st == ST_LOCK) || (st == ST_DUMP) || (st == ST_FLT);
  assign ramp_hold = (st == ST_LOCK) || (st == ST_PRE) || (st == ST_DUMP) || (st == ST_FLT);
  assign reg_sink  = (st == ST_IGN) && s_oc && !oc_d;
endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_en,
  input logic       cap_dump,
  input logic       ramp_hold,
  input logic       reg_sink,
  input logic [2:0] mode
);
  AST_PRE_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && $past(mode) != 3'd1) |-> $past(mode) == 3'd0); // R2
  AST_IGN_FROM_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && $past(mode) != 3'd3) |-> $past(mode) == 3'd2); // R4
  AST_DUMP_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (cap_dump && osc_en && ramp_hold)); // R4
  AST_SINK_IGN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sink |-> mode == 3'd3); // R5
  AST_SINK_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sink |=> !reg_sink); // R5
  AST_RUN_FROM_PRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && $past(mode) != 3'd5) |-> $past(mode) == 3'd4); // R7
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7) |-> (!osc_en && cap_dump && ramp_hold)); // R9
  AST_FAULT_EXIT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd7 && mode != 3'd7) |-> mode == 3'd0); // R10
endmodule

bind ballast_seq ballast_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cap_dump(cap_dump),
  .ramp_hold(ramp_hold), .reg_sink(reg_sink), .mode(mode)
);

// File: tb/ballast_seq_tb.sv
module ballast_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vdd_on, vdd_off, bus_en, bus_dis, sd_low, sd_high;
  logic tc_third, tc_half, tc_2third, oc_over, cnt_trip, eol_trip;
  logic osc_en, cap_dump, ramp_hold, reg_sink;
  logic [2:0] mode;
  int checks = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ballast_seq u_dut (.*);

  logic [11:0] m1, m2, vin;
  logic [2:0]  m_st;
  logic        m_ocd;

  assign vin = {eol_trip, cnt_trip, oc_over, tc_2third, tc_half, tc_third,
                sd_high, sd_low, bus_dis, bus_en, vdd_off, vdd_on};

  function automatic logic [2:0] nxt(logic [2:0] s, logic [11:0] v);
    logic lk;
    lk = v[1] | v[3];
    case (s)
      3'd0: return (v[0] & v[2] & v[4]) ? 3'd1 : 3'd0;
      3'd7: return (v[1] | v[5]) ? 3'd0 : 3'd7;
      3'd1: return lk ? 3'd0 : v[10] ? 3'd7 : v[8] ? 3'd2 : 3'd1;
      3'd2: return lk ? 3'd0 : v[10] ? 3'd7 : !v[6] ? 3'd3 : 3'd2;
      3'd3: return lk ? 3'd0 : v[7] ? 3'd4 : 3'd3;
      3'd4: return lk ? 3'd0 : v[9] ? 3'd7 : v[8] ? 3'd5 : 3'd4;
      3'd5: return lk ? 3'd0 : (v[10] | v[11]) ? 3'd7 : 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] s);
    case (s)
      3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4";
      3'd3: return "R6"; 3'd4: return "R7"; 3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; m_st <= 3'd0; m_ocd <= 1'b0;
    end else begin
      m1 <= vin; m2 <= m1; m_st <= nxt(m_st, m2); m_ocd <= m2[9];
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [3:0] e, a;
    e = {m_st == 3'd1 || m_st == 3'd2 || m_st == 3'd3 || m_st == 3'd4 || m_st == 3'd5,
         m_st == 3'd0 || m_st == 3'd2 || m_st == 3'd7,
         m_st == 3'd0 || m_st == 3'd1 || m_st == 3'd2 || m_st == 3'd7,
         m_st == 3'd3 && m2[9] && !m_ocd};
    a = {osc_en, cap_dump, ramp_hold, reg_sink};
    chk(mode == m_st, tag_of(m_st), mode, m_st);
    chk(a == e, (m_st == 3'd3) ? "R5" : "R1", a, e);
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic caps(int lvl);
    tc_third = lvl >= 1; tc_half = lvl >= 2; tc_2third = lvl >= 3;
  endtask

  task automatic base();
    vdd_on = 1; vdd_off = 0; bus_en = 1; bus_dis = 0; sd_low = 1; sd_high = 0;
    caps(0); oc_over = 0; cnt_trip = 0; eol_trip = 0;
  endtask

  task automatic to_prerun();
    base(); wt(3); caps(3); wt(3); caps(0); wt(3); caps(2); wt(3);
    chk(mode == 3'd4, "R6", mode, 4);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    vdd_on = 0; vdd_off = 1; bus_en = 0; bus_dis = 1; sd_low = 1; sd_high = 0;
    caps(0); oc_over = 0; cnt_trip = 0; eol_trip = 0;
    wt(3);
    chk(mode == 0 && !osc_en && cap_dump && ramp_hold, "R1", mode, 0);
    rst_n = 1;
    wt(2);
    chk(mode == 0 && !osc_en && cap_dump && ramp_hold, "R1", mode, 0);
    // R2: missing shutdown-low keeps lockout
    vdd_on = 1; vdd_off = 0; bus_en = 1; bus_dis = 0; sd_low = 0;
    wt(6); chk(mode == 0, "R2", mode, 0);
    sd_low = 1; wt(2); chk(mode == 0, "R2", mode, 0);
    wt(1); chk(mode == 1, "R2", mode, 1);
    chk(osc_en && !cap_dump && ramp_hold, "R3", {osc_en, cap_dump, ramp_hold}, 3'b101);
    caps(3); wt(3); chk(mode == 2 && cap_dump, "R4", mode, 2);
    caps(0); wt(3); chk(mode == 3 && !ramp_hold && !cap_dump, "R4", mode, 3);
    oc_over = 1; wt(2); chk(reg_sink == 1, "R5", reg_sink, 1);
    wt(1); chk(reg_sink == 0 && mode == 3, "R5", reg_sink, 0);
    oc_over = 0; cnt_trip = 1; eol_trip = 1; wt(4); chk(mode == 3, "R8", mode, 3);
    cnt_trip = 0; eol_trip = 0;
    caps(2); wt(3); chk(mode == 4, "R6", mode, 4);
    cnt_trip = 1; wt(4); chk(mode == 4, "R8", mode, 4);
    cnt_trip = 0; caps(3); wt(3);
    chk(mode == 5 && osc_en && !ramp_hold && !cap_dump, "R7", mode, 5);
    eol_trip = 1; wt(3); chk(mode == 7 && !osc_en, "R8", mode, 7);
    eol_trip = 0; caps(0); oc_over = 1; bus_dis = 1; wt(5);
    chk(mode == 7 && cap_dump && ramp_hold, "R9", mode, 7);
    bus_dis = 0; oc_over = 0; sd_low = 0; sd_high = 1; wt(3);
    chk(mode == 0, "R10", mode, 0);
    sd_high = 0; sd_low = 1; wt(3); chk(mode == 1, "R11", mode, 1);
    bus_en = 0; bus_dis = 1; wt(3); chk(mode == 0, "R11", mode, 0);
    to_prerun();
    oc_over = 1; vdd_on = 0; vdd_off = 1; wt(3); chk(mode == 0, "R12", mode, 0);
    to_prerun();
    oc_over = 1; wt(3); chk(mode == 7, "R6", mode, 7);
    oc_over = 0; vdd_on = 0; vdd_off = 1; wt(3); chk(mode == 0, "R10", mode, 0);
    to_prerun(); caps(3); wt(3);
    cnt_trip = 1; wt(3); chk(mode == 7, "R8", mode, 7);
    // random phase, checked cycle by cycle against the model
    base();
    for (int i = 0; i < 600; i++) begin
      int s;
      s = $urandom_range(0, 19);
      vdd_on = s > 1; vdd_off = s == 0;
      s = $urandom_range(0, 19);
      bus_en = s > 1; bus_dis = s == 0;
      s = $urandom_range(0, 19);
      sd_low = s > 1; sd_high = s == 0;
      caps($urandom_range(0, 3));
      oc_over = $urandom_range(0, 5) == 0;
      cnt_trip = $urandom_range(0, 15) == 0;
      eol_trip = $urandom_range(0, 15) == 0;
      wt($urandom_range(1, 8));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule